// File: doc/BRIEF.md
# Dual Serial Temperature Sensor Reader

This block reads two digital temperature sensors in one shared transaction. Both sensors hang off a common select line and a common serial clock. Each sensor returns its conversion on its own data line, so one frame delivers both readings side by side.

A single-cycle `start` launches a fixed frame of 40 line steps:
- a framing preamble of five steps;
- sixteen clocked data bits of two steps each;
- a three-step release sequence.

Every step holds its select and clock levels for `HOLD` system clocks, so one parameter stretches the serial clock period to suit the sensor. When the frame ends, the block publishes two things for each sensor: a signed 14-bit temperature in units of 1/32 °C and a valid flag. It then raises `done` for one cycle.

Top module: `dual_temp_reader`

## Requirements
- R1: After reset, and whenever no frame is running, `sclk` is low, `csel` is high and `busy` is low. After reset, `done`, both valid flags and both temperatures are 0.
- R2: A `start` seen while idle begins a frame. `busy` is then high for exactly 40*HOLD clocks, made of 40 steps whose line levels each last HOLD clocks.
- R3: Steps 0 to 4 drive ({sclk,csel}) in this order: (0,1), (1,1), (0,1), (1,1), (0,0).
- R4: Steps 5 to 36 alternate: odd steps drive (1,0) and even steps drive (0,0). Each data line is sampled in the last clock of each high step. The first sampled bit is bit 15 of the code.
- R5: Steps 37 to 39 drive (0,1), (1,1), (0,1). In the clock after step 39, `busy` is low and `done` is high for exactly one cycle.
- R6: For a valid code, the temperature output equals the 16-bit two's-complement code arithmetically shifted right by 2, which is bits 15..2. One LSB is 1/32 °C.
- R7: Each channel is judged on its own. A code of 0x0000 or 0xFFFF gives valid=0 and temperature 0. Any other code gives valid=1.
- R8: A `start` that arrives while a frame is running is ignored, and the frame keeps its length and waveform.
- R9: Temperatures and valid flags change only in the cycle in which `done` is high, and otherwise keep their last values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a frame (honoured only while idle) |
| sdat_a | input | 1 | Serial data from sensor A |
| sdat_b | input | 1 | Serial data from sensor B |
| sclk | output | 1 | Shared serial clock to both sensors |
| csel | output | 1 | Shared select line to both sensors |
| busy | output | 1 | High while a frame runs |
| done | output | 1 | One-cycle pulse when results update |
| temp_a | output | 14 | Sensor A temperature, signed, 1/32 °C per LSB |
| temp_b | output | 14 | Sensor B temperature, signed, 1/32 °C per LSB |
| valid_a | output | 1 | Sensor A code was not all ones or all zeros |
| valid_b | output | 1 | Sensor B code was not all ones or all zeros |

## Verification
The bench feeds the two sensors codes that differ in sign and in validity. A positive code on one line paired with a negative code on the other shows that the channels are not swapped and that the sign is extended. All-zero and all-one codes, set against 0x0001 and 0xFFFE, separate the invalid-code rule from a plain sign or magnitude test. A `start` pulse in the middle of a frame, together with a step-by-step comparison of the recorded line levels, exposes any restart, any wrong step order or any wrong hold length. The sensor model shifts its bits out on rising serial clock edges, so a sample point taken in the wrong step reads a wrong bit.

// File: rtl/dual_temp_reader.sv
module dual_temp_reader #(
  parameter int HOLD   = 4,
  parameter int CODE_W = 16,
  parameter int SHIFT  = 2
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              start,
  input  logic                              sdat_a,
  input  logic                              sdat_b,
  output logic                              sclk,
  output logic                              csel,
  output logic                              busy,
  output logic                              done,
  output logic signed [CODE_W-SHIFT-1:0]    temp_a,
  output logic signed [CODE_W-SHIFT-1:0]    temp_b,
  output logic                              valid_a,
  output logic                              valid_b
);
  localparam int TEMP_W   = CODE_W - SHIFT;
  localparam int PRE_N    = 5;
  localparam int DATA_N   = 2 * CODE_W;
  localparam int POST_N   = 3;
  localparam int LAST     = PRE_N + DATA_N + POST_N - 1;
  localparam int STEP_W   = $clog2(LAST + 1);
  localparam int HOLD_W   = (HOLD < 2) ? 1 : $clog2(HOLD);

  logic [STEP_W-1:0] step_q;
  logic [HOLD_W-1:0] hold_q;
  logic [CODE_W-1:0] sh_a, sh_b;
  logic              in_pre, in_data, hi_data, hold_end, last_step;

  assign in_pre    = step_q < STEP_W'(PRE_N);
  assign in_data   = !in_pre && (step_q < STEP_W'(PRE_N + DATA_N));
  assign hi_data   = in_data && step_q[0];
  assign hold_end  = hold_q == HOLD_W'(HOLD - 1);
  assign last_step = step_q == STEP_W'(LAST);

  assign sclk = busy && (in_pre  ? step_q[0] :
                         in_data ? hi_data   :
                                   (step_q == STEP_W'(LAST - 1)));
  assign csel = !busy || !(in_data || step_q == STEP_W'(PRE_N - 1));

  function automatic logic code_ok(input logic [CODE_W-1:0] c);
    return (|c) && !(&c);
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      done    <= 1'b0;
      step_q  <= '0;
      hold_q  <= '0;
      sh_a    <= '0;
      sh_b    <= '0;
      temp_a  <= '0;
      temp_b  <= '0;
      valid_a <= 1'b0;
      valid_b <= 1'b0;
    end else begin
      done <= 1'b0;
      if (!busy) begin
        if (start) begin
          busy   <= 1'b1;
          step_q <= '0;
          hold_q <= '0;
        end
      end else begin
        if (hi_data && hold_end) begin
          sh_a <= {sh_a[CODE_W-2:0], sdat_a};
          sh_b <= {sh_b[CODE_W-2:0], sdat_b};
        end
        if (!hold_end) begin
          hold_q <= hold_q + 1'b1;
        end else begin
          hold_q <= '0;
          if (last_step) begin
            busy    <= 1'b0;
            done    <= 1'b1;
            valid_a <= code_ok(sh_a);
            valid_b <= code_ok(sh_b);
            temp_a  <= code_ok(sh_a) ? sh_a[CODE_W-1:SHIFT] : TEMP_W'(0);
            temp_b  <= code_ok(sh_b) ? sh_b[CODE_W-1:SHIFT] : TEMP_W'(0);
          end else begin
            step_q <= step_q + 1'b1;
          end
        end
      end
    end
  end
endmodule

// File: rtl/dual_temp_reader_chk.sv
module dual_temp_reader_chk #(
  parameter int TEMP_W = 14
) (
  input logic              clk,
  input logic              rst_n,
  input logic              busy,
  input logic              done,
  input logic              sclk,
  input logic              csel,
  input logic [TEMP_W-1:0] temp_a,
  input logic [TEMP_W-1:0] temp_b,
  input logic              valid_a,
  input logic              valid_b
);
  assert_idle_lines_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (csel && !sclk));

  assert_sclk_in_frame_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sclk) |-> busy);

  assert_done_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_done_after_frame_R5: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && $past(busy)));

  assert_invalid_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!valid_a |-> temp_a == '0) and (!valid_b |-> temp_b == '0));

  assert_results_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> ($stable(temp_a) && $stable(temp_b) && $stable(valid_a) && $stable(valid_b)));
endmodule

bind dual_temp_reader dual_temp_reader_chk #(.TEMP_W(CODE_W - SHIFT)) chk_i (
  .clk(clk), .rst_n(rst_n), .busy(busy), .done(done), .sclk(sclk), .csel(csel),
  .temp_a(temp_a), .temp_b(temp_b), .valid_a(valid_a), .valid_b(valid_b)
);

// File: tb/dual_temp_reader_tb_top.sv
module dual_temp_reader_tb_top;
  localparam int HOLD  = 3;
  localparam int STEPS = 40;
  localparam int NCYC  = STEPS * HOLD;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic sdat_a, sdat_b, sclk, csel, busy, done, valid_a, valid_b;
  logic signed [13:0] temp_a, temp_b;
  logic [15:0] word_a = '0, word_b = '0;
  int bit_k = 0;
  int checks = 0, errors = 0;
  bit finished = 1'b0;
  logic [1:0] lv [NCYC];

  always #2.5 clk = ~clk;

  dual_temp_reader #(.HOLD(HOLD)) dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .sdat_a(sdat_a), .sdat_b(sdat_b),
    .sclk(sclk), .csel(csel), .busy(busy), .done(done),
    .temp_a(temp_a), .temp_b(temp_b), .valid_a(valid_a), .valid_b(valid_b)
  );

  always @(negedge csel) bit_k = 0;
  always @(posedge sclk) if (!csel) bit_k = bit_k + 1;
  assign sdat_a = (bit_k >= 1 && bit_k <= 16) ? word_a[16 - bit_k] : 1'b0;
  assign sdat_b = (bit_k >= 1 && bit_k <= 16) ? word_b[16 - bit_k] : 1'b0;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic logic [1:0] exp_lv(input int s);
    if (s < 4)  return {s[0], 1'b1};
    if (s == 4) return 2'b00;
    if (s < 37) return {s[0], 1'b0};
    return {(s == 38), 1'b1};
  endfunction

  function automatic int exp_temp(input logic [15:0] w);
    if (w == 16'h0000 || w == 16'hFFFF) return 0;
    return int'(w[15:2]);
  endfunction

  function automatic bit exp_valid(input logic [15:0] w);
    return !(w == 16'h0000 || w == 16'hFFFF);
  endfunction

  task automatic run_frame(input logic [15:0] wa, input logic [15:0] wb, input int poke_at);
    int cyc = 0;
    int bad = 0;
    word_a = wa;
    word_b = wb;
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    while (busy && cyc < NCYC + 10) begin
      if (cyc < NCYC) lv[cyc] = {sclk, csel};
      cyc++;
      start = (cyc == poke_at);
      @(negedge clk);
    end
    start = 1'b0;
    check(cyc == NCYC, "R2 busy length", cyc, NCYC);
    for (int s = 0; s < STEPS; s++)
      for (int h = 0; h < HOLD; h++)
        if (s * HOLD + h < cyc && lv[s * HOLD + h] != exp_lv(s)) bad++;
    check(bad == 0, "R3/R4/R5 line waveform mismatches", bad, 0);
    check(done == 1'b1, "R5 done after frame", done, 1);
    check(temp_a == 14'(exp_temp(wa)), "R6 temp_a", temp_a, exp_temp(wa) & 16'h3FFF);
    check(temp_b == 14'(exp_temp(wb)), "R6 temp_b", temp_b, exp_temp(wb) & 16'h3FFF);
    check(valid_a == exp_valid(wa), "R7 valid_a", valid_a, exp_valid(wa));
    check(valid_b == exp_valid(wb), "R7 valid_b", valid_b, exp_valid(wb));
    @(negedge clk);
    check(done == 1'b0, "R5 done single cycle", done, 0);
    check(busy == 1'b0 && csel && !sclk, "R1 idle lines after frame", {busy, sclk, csel}, 3'b001);
  endtask

  task automatic test_reset;
    check(!busy && !done && csel && !sclk, "R1 reset lines", {busy, done, sclk, csel}, 4'b0001);
    check(temp_a == 0 && temp_b == 0 && !valid_a && !valid_b, "R1 reset results",
          {temp_a, temp_b, valid_a, valid_b}, 0);
  endtask

  task automatic test_signs;
    run_frame(16'h0C80, 16'hF380, 0);
  endtask

  task automatic test_invalid;
    run_frame(16'h0000, 16'hFFFF, 0);
    run_frame(16'hFFFF, 16'h0001, 0);
    run_frame(16'hFFFE, 16'h0000, 0);
  endtask

  task automatic test_busy_start;
    run_frame(16'h5A5C, 16'h8004, 17);
    check(bit_k == 16, "R8 one data burst only", bit_k, 16);
  endtask

  task automatic test_hold;
    logic signed [13:0] ta = temp_a, tb = temp_b;
    word_a = 16'h1234;
    word_b = 16'h4321;
    repeat (25) @(negedge clk);
    check(temp_a == ta && temp_b == tb && !busy, "R9 results held while idle", temp_a, ta);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    test_reset();
    rst_n = 1'b1;
    @(negedge clk);
    test_reset();
    test_signs();
    test_invalid();
    test_busy_start();
    test_hold();
    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule